// File: doc/BRIEF.md
# Fourth-power QPSK carrier phase detector

This block turns one pair of simultaneous in-phase and quadrature samples from a homodyne QPSK receiver into a signed carrier phase-error word. It treats the sample pair as the complex number z = I + jQ and raises it to the fourth power. Every QPSK symbol phase (a multiple of 90 degrees) then lands on the same point, so the data modulation no longer affects the result. The fourth power is divided by |z|^4, which removes the signal amplitude. The imaginary part of that unit-magnitude value is sin(4·phi), where phi is the carrier phase error. Near lock the output is close to 4·phi and can drive a loop filter directly.

The datapath accepts one sample pair on every clock. It is a three-stage pipeline. The first stage forms the squared terms of z^2. The second stage forms the fourth-power numerator and denominator and starts an exact restoring division. The third stage finishes the division and applies the sign. A valid flag travels with the data. The 90-degree ambiguity of a fourth-power loop is left to the logic downstream.

Top module: `qpsk_quartic_detector`

## Requirements
- R1: Every clock with `in_vld` high produces exactly one result, with `out_vld` high exactly 3 clocks later. `out_vld` is low in every other cycle, and a new sample pair can be accepted on every clock.
- R2: `in_i` and `in_q` are two's complement. For a sample pair other than (0,0), `phase_err` is two's complement and equals 511·Im(z^4)/|z|^4, rounded to the nearest integer with halves rounded away from zero. Here Im(z^4) = 4·I·Q·(I²−Q²) and |z|^4 = (I²+Q²)².
- R3: The sample pair I = 0, Q = 0 yields `phase_err` = 0.
- R4: Multiplying both I and Q by the same integer leaves the result unchanged (independence from amplitude).
- R5: Rotating the input by 90 degrees, (I,Q) to (−Q,I), leaves the result unchanged.
- R6: A sample pair on an axis or on a diagonal (I = 0, Q = 0, I = Q or I = −Q) yields `phase_err` = 0.
- R7: `phase_err` always lies in −511..+511. The code −512 never appears.
- R8: While `out_vld` is low, `phase_err` holds its last value.
- R9: While `rst_n` is low, `out_vld` is 0 and `phase_err` is 0.
- R10: A small positive carrier rotation gives a positive result, and a small negative rotation gives a negative result. For example, (63,1) is positive and (63,−1) is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| in_vld | input | 1 | High when `in_i`/`in_q` carry a sample pair |
| in_i | input | IN_W (7) | In-phase sample, two's complement |
| in_q | input | IN_W (7) | Quadrature sample, two's complement |
| out_vld | output | 1 | High when `phase_err` carries a new result |
| phase_err | output | OUT_W (10) | Phase-error word, 511 = +1.0 |

## Verification
A valid flag lost or duplicated inside the pipeline shows at the ports as `out_vld` out of step with `in_vld` three clocks earlier. The error therefore appears within three cycles of the faulty sample. A wrong quotient bit or a wrong sign from the divider changes the value of the matching result, so the full 128×128 input sweep compares every word against the arithmetic rounding rule. A fault that is symmetric in value but breaks the sign handling would leave some single results correct. It shows instead as a mismatch between pairs of results that the rotation and scaling requirements tie together. Corruption of the hold path shows as `phase_err` moving during the idle cycles inserted in the sweep.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

  // Sideband tag carried alongside each pipeline stage
  typedef struct packed {
    logic vld;   // stage holds a live result
    logic neg;   // final result is negative
    logic zero;  // input pair was (0,0): force result to zero
  } qpd_tag_t;

  // Largest positive code of a two's complement word of width w
  function automatic int unsigned full_scale(input int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/qpd_square_terms.sv
// Stage-one arithmetic: z^2 = a + jb with a = I^2 - Q^2, b = 2IQ,
// and |z|^2 = I^2 + Q^2, all returned as magnitudes plus a sign.
module qpd_square_terms #(
  parameter int IN_W = 7,
  parameter int M_W  = 2 * IN_W + 1
) (
  input  logic [IN_W-1:0] smp_i,
  input  logic [IN_W-1:0] smp_q,
  output logic [M_W-1:0]  a_mag,
  output logic [M_W-1:0]  b_mag,
  output logic [M_W-1:0]  m_sum,
  output logic            prod_neg,
  output logic            is_zero
);

  logic signed [M_W-1:0] si, sq;
  logic signed [M_W-1:0] ii, qq, iq;
  logic signed [M_W-1:0] a_s, b_s;

  always_comb begin
    si = {{(M_W-IN_W){smp_i[IN_W-1]}}, smp_i};
    sq = {{(M_W-IN_W){smp_q[IN_W-1]}}, smp_q};
    ii = si * si;
    qq = sq * sq;
    iq = si * sq;
    a_s = ii - qq;
    b_s = iq <<< 1;
    a_mag = a_s[M_W-1] ? M_W'(-a_s) : M_W'(a_s);
    b_mag = b_s[M_W-1] ? M_W'(-b_s) : M_W'(b_s);
    m_sum = M_W'(ii + qq);
    prod_neg = a_s[M_W-1] ^ b_s[M_W-1];
    is_zero  = (smp_i == '0) && (smp_q == '0);
  end

endmodule

// File: rtl/qpd_div_slice.sv
// A run of STEPS restoring-division steps that produces quotient bits
// TOP down to TOP-STEPS+1 of rem_i / den_i.
module qpd_div_slice #(
  parameter int DIV_W = 42,
  parameter int Q_W   = 9,
  parameter int TOP   = 8,
  parameter int STEPS = 5
) (
  input  logic [DIV_W-1:0] rem_i,
  input  logic [DIV_W-1:0] den_i,
  input  logic [Q_W-1:0]   quo_i,
  output logic [DIV_W-1:0] rem_o,
  output logic [Q_W-1:0]   quo_o
);

  logic [DIV_W-1:0] rem_v;
  logic [DIV_W-1:0] sub_v;
  logic [Q_W-1:0]   quo_v;

  always_comb begin
    rem_v = rem_i;
    quo_v = quo_i;
    sub_v = '0;
    for (int s = 0; s < STEPS; s++) begin
      sub_v = den_i << (TOP - s);
      if (rem_v >= sub_v) begin
        rem_v = rem_v - sub_v;
        quo_v[TOP-s] = 1'b1;
      end
    end
    rem_o = rem_v;
    quo_o = quo_v;
  end

endmodule

// File: rtl/qpd_sign_apply.sv
// Final stage: attach sign to the rounded magnitude, force zero input to 0.
module qpd_sign_apply #(
  parameter int Q_W   = 9,
  parameter int OUT_W = Q_W + 1
) (
  input  logic [Q_W-1:0]   mag,
  input  logic             neg,
  input  logic             zero,
  output logic [OUT_W-1:0] value
);

  logic [OUT_W-1:0] ext;

  always_comb begin
    ext = OUT_W'(mag);
    if (zero)
      value = '0;
    else if (neg)
      value = -ext;
    else
      value = ext;
  end

endmodule

// File: rtl/qpsk_quartic_detector.sv
module qpsk_quartic_detector #(
  parameter int IN_W  = 7,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_i,
  input  logic [IN_W-1:0]  in_q,
  output logic             out_vld,
  output logic [OUT_W-1:0] phase_err
);
  import qpd_pkg::*;

  localparam int M_W   = 2 * IN_W + 1;          // z^2 component magnitude
  localparam int P_W   = 2 * M_W;               // product / square width
  localparam int Q_W   = OUT_W - 1;             // quotient magnitude bits
  localparam int DIV_W = P_W + OUT_W + 2;       // dividend width
  localparam int Q_HI  = Q_W - Q_W / 2;         // bits resolved in stage 2
  localparam int Q_LO  = Q_W / 2;               // bits resolved in stage 3
  localparam int unsigned FULL = full_scale(OUT_W);
  localparam logic [DIV_W-1:0] SCALE = DIV_W'(4 * FULL);

  // ---------------- stage 1: squared terms ----------------
  logic [M_W-1:0] sq_a, sq_b, sq_m;
  logic           sq_neg, sq_zero;

  qpd_square_terms #(.IN_W(IN_W), .M_W(M_W)) u_sq (
    .smp_i   (in_i),
    .smp_q   (in_q),
    .a_mag   (sq_a),
    .b_mag   (sq_b),
    .m_sum   (sq_m),
    .prod_neg(sq_neg),
    .is_zero (sq_zero)
  );

  logic [M_W-1:0] s1_a_q, s1_a_d, s1_b_q, s1_b_d, s1_m_q, s1_m_d;
  qpd_tag_t       s1_tag_q, s1_tag_d;

  always_comb begin
    s1_a_d   = s1_a_q;
    s1_b_d   = s1_b_q;
    s1_m_d   = s1_m_q;
    s1_tag_d = s1_tag_q;
    s1_tag_d.vld = in_vld;
    if (in_vld) begin
      s1_a_d = sq_a;
      s1_b_d = sq_b;
      s1_m_d = sq_m;
      s1_tag_d.neg  = sq_neg;
      s1_tag_d.zero = sq_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_a_q   <= '0;
      s1_b_q   <= '0;
      s1_m_q   <= '0;
      s1_tag_q <= '0;
    end else begin
      s1_a_q   <= s1_a_d;
      s1_b_q   <= s1_b_d;
      s1_m_q   <= s1_m_d;
      s1_tag_q <= s1_tag_d;
    end
  end

  // ---------------- stage 2: fourth power, upper quotient bits ----------------
  // |result| = round(FULL * 2|a||b| / m^2) = floor((4*FULL*|a||b| + m^2) / (2*m^2))
  logic [P_W-1:0]   ab_prod, m_sq;
  logic [DIV_W-1:0] dividend, divisor;
  logic [DIV_W-1:0] hi_rem;
  logic [Q_W-1:0]   hi_quo;

  always_comb begin
    ab_prod  = P_W'(s1_a_q) * P_W'(s1_b_q);
    m_sq     = P_W'(s1_m_q) * P_W'(s1_m_q);
    dividend = DIV_W'(ab_prod) * SCALE + DIV_W'(m_sq);
    divisor  = DIV_W'(m_sq) << 1;
  end

  qpd_div_slice #(.DIV_W(DIV_W), .Q_W(Q_W), .TOP(Q_W - 1), .STEPS(Q_HI)) u_div_hi (
    .rem_i(dividend),
    .den_i(divisor),
    .quo_i('0),
    .rem_o(hi_rem),
    .quo_o(hi_quo)
  );

  logic [DIV_W-1:0] s2_rem_q, s2_rem_d, s2_den_q, s2_den_d;
  logic [Q_W-1:0]   s2_quo_q, s2_quo_d;
  qpd_tag_t         s2_tag_q, s2_tag_d;

  always_comb begin
    s2_rem_d = s2_rem_q;
    s2_den_d = s2_den_q;
    s2_quo_d = s2_quo_q;
    s2_tag_d = s2_tag_q;
    s2_tag_d.vld = s1_tag_q.vld;
    if (s1_tag_q.vld) begin
      s2_rem_d = hi_rem;
      s2_den_d = divisor;
      s2_quo_d = hi_quo;
      s2_tag_d.neg  = s1_tag_q.neg;
      s2_tag_d.zero = s1_tag_q.zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_rem_q <= '0;
      s2_den_q <= '0;
      s2_quo_q <= '0;
      s2_tag_q <= '0;
    end else begin
      s2_rem_q <= s2_rem_d;
      s2_den_q <= s2_den_d;
      s2_quo_q <= s2_quo_d;
      s2_tag_q <= s2_tag_d;
    end
  end

  // ---------------- stage 3: lower quotient bits, sign ----------------
  logic [DIV_W-1:0] lo_rem_unused;
  logic [Q_W-1:0]   lo_quo;
  logic [OUT_W-1:0] signed_val;

  qpd_div_slice #(.DIV_W(DIV_W), .Q_W(Q_W), .TOP(Q_LO - 1), .STEPS(Q_LO)) u_div_lo (
    .rem_i(s2_rem_q),
    .den_i(s2_den_q),
    .quo_i(s2_quo_q),
    .rem_o(lo_rem_unused),
    .quo_o(lo_quo)
  );

  qpd_sign_apply #(.Q_W(Q_W), .OUT_W(OUT_W)) u_sign (
    .mag  (lo_quo),
    .neg  (s2_tag_q.neg),
    .zero (s2_tag_q.zero),
    .value(signed_val)
  );

  logic [OUT_W-1:0] pe_d;
  logic             ov_d;

  always_comb begin
    pe_d = phase_err;
    ov_d = s2_tag_q.vld;
    if (s2_tag_q.vld)
      pe_d = signed_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_err <= '0;
      out_vld   <= 1'b0;
    end else begin
      phase_err <= pe_d;
      out_vld   <= ov_d;
    end
  end

endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int IN_W  = 7,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_i,
  input logic [IN_W-1:0]  in_q,
  input logic             out_vld,
  input logic [OUT_W-1:0] phase_err
);

  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [IN_W-1:0] iq_sum;
  logic            on_grid;

  always_comb begin
    iq_sum  = in_i + in_q;
    on_grid = (in_i == '0) || (in_q == '0) || (in_i == in_q) || (iq_sum == '0);
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##3 out_vld);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> ##3 !out_vld);

  a_r3_zero_input: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_i == '0 && in_q == '0) |-> ##3 (phase_err == '0));

  a_r6_axis_diag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && on_grid) |-> ##3 (phase_err == '0));

  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (phase_err != MOST_NEG));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(phase_err));

endmodule

bind qpsk_quartic_detector qpd_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_qpd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_i     (in_i),
  .in_q     (in_q),
  .out_vld  (out_vld),
  .phase_err(phase_err)
);

// File: tb/qpsk_quartic_detector_test.sv
module qpsk_quartic_detector_test;

  localparam int CLK_PERIOD = 8;
  localparam int IN_W  = 7;
  localparam int OUT_W = 10;
  localparam int LAT   = 3;

  logic             clk;
  logic             rst_n;
  logic             in_vld;
  logic [IN_W-1:0]  in_i, in_q;
  logic             out_vld;
  logic [OUT_W-1:0] phase_err;

  qpsk_quartic_detector #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .phase_err(phase_err)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;
  longint cyc   = 0;

  int     exp_q[$];
  longint stamp_q[$];
  int     key_q[$];
  int     tab [0:16383];
  int     last_out = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int key_of(int i, int q);
    return (i + 64) * 128 + (q + 64);
  endfunction

  // R2: round-half-away of 511 * 4IQ(I^2-Q^2) / (I^2+Q^2)^2
  function automatic int expect_pe(int i, int q);
    longint num, den, mag;
    num = 4 * longint'(i) * longint'(q) * (longint'(i) * i - longint'(q) * q);
    den = (longint'(i) * i + longint'(q) * q) * (longint'(i) * i + longint'(q) * q);
    if (den == 0) return 0;
    mag = (1022 * (num < 0 ? -num : num) + den) / (2 * den);
    return int'(num < 0 ? -mag : mag);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Output monitor: R1 latency, R2 value, R7 range, R8 hold
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected out_vld", 1, 0);
        end else begin
          int     e, k, act;
          longint st;
          e  = exp_q.pop_front();
          st = stamp_q.pop_front();
          k  = key_q.pop_front();
          act = int'($signed(phase_err));
          check(cyc == st + LAT, "R1", "latency", cyc - st, LAT);
          check(act == e, "R2", $sformatf("value key=%0d", k), act, e);
          check(act >= -511 && act <= 511, "R7", "range", act, 511);
          tab[k]  = act;
          last_out = act;
        end
      end else begin
        check(int'($signed(phase_err)) == last_out, "R8", "hold while idle",
              int'($signed(phase_err)), last_out);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int k = 0; k < 16384; k++) tab[k] = 9999;
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_i   = '0;
    in_q   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b0, "R9", "out_vld in reset", out_vld, 0);
    check(phase_err == '0, "R9", "phase_err in reset", int'($signed(phase_err)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0 && phase_err == '0, "R9", "state after release",
          int'($signed(phase_err)), 0);

    // Exhaustive sweep with idle gaps (R1, R2, R7, R8)
    n = 0;
    for (int i = -64; i < 64; i++) begin
      for (int q = -64; q < 64; q++) begin
        if (n % 13 == 12) begin
          in_vld = 1'b0;
          @(negedge clk);
        end
        in_vld = 1'b1;
        in_i   = IN_W'(i);
        in_q   = IN_W'(q);
        exp_q.push_back(expect_pe(i, q));
        stamp_q.push_back(cyc);
        key_q.push_back(key_of(i, q));
        n++;
        @(negedge clk);
      end
    end
    in_vld = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    check(exp_q.size() == 0, "R1", "results outstanding", exp_q.size(), 0);

    // R3: zero input
    check(tab[key_of(0, 0)] == 0, "R3", "zero input", tab[key_of(0, 0)], 0);

    // R6: axis and diagonal symbols
    for (int i = -64; i < 64; i++) begin
      for (int q = -64; q < 64; q++) begin
        if (i == 0 || q == 0 || i == q || i == -q)
          check(tab[key_of(i, q)] == 0, "R6", $sformatf("grid (%0d,%0d)", i, q),
                tab[key_of(i, q)], 0);
      end
    end

    // R4: doubling amplitude
    for (int i = -32; i < 32; i++) begin
      for (int q = -32; q < 32; q++) begin
        check(tab[key_of(2 * i, 2 * q)] == tab[key_of(i, q)], "R4",
              $sformatf("scale (%0d,%0d)", i, q),
              tab[key_of(2 * i, 2 * q)], tab[key_of(i, q)]);
      end
    end

    // R5: 90-degree rotation (I,Q) -> (-Q,I)
    for (int i = -64; i < 64; i++) begin
      for (int q = -63; q < 64; q++) begin
        check(tab[key_of(-q, i)] == tab[key_of(i, q)], "R5",
              $sformatf("rotate (%0d,%0d)", i, q),
              tab[key_of(-q, i)], tab[key_of(i, q)]);
      end
    end

    // R10: sign of small rotations
    check(tab[key_of(63, 1)] > 0, "R10", "positive rotation", tab[key_of(63, 1)], 1);
    check(tab[key_of(63, -1)] < 0, "R10", "negative rotation", tab[key_of(63, -1)], -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule